// File: doc/BRIEF.md
# Microstep Translator Step Indexer

This block turns step pulses and a direction level into winding current commands for a two-phase bipolar stepper motor. It holds a position index on a circle of 32 positions, 11.25 degrees apart. Each rising edge on the step input moves the index by one full, half, quarter or eighth step. For each phase it drives a magnitude code and a polarity bit, which feed a current DAC outside this block. It also drives a home flag and a decay-mode request for each phase, which feed the current regulator.

The step input may be asynchronous, so it passes through a synchroniser before its edge is detected. Two conditions force the indexer back to its home position, which is the 45 degree point: the active-low driver reset input and the undervoltage input. While either is active the bridges are commanded off and step edges are dropped. Mode select and direction are plain level inputs. They are taken in the cycle in which the synchronised edge is applied. The block has no data stream and no handshake: every pin is a plain control or status pin.

Top module: `ustep_indexer`

## Requirements
- R1: After the system reset, the index sits at position 4 (45 degrees). Both magnitude codes are 4, both polarity bits are 0, `home_n` is 0 and `out_en` is 0.
- R2: Step size comes from `{ms_b,ms_a}`. 00 gives full step (8 positions), 01 gives half step (4), 10 gives quarter step (2) and 11 gives eighth step (1).
- R3: Only a rising edge of `step_in` moves the index. `dir`=1 adds the step size and `dir`=0 subtracts it. A falling edge, or a level held high, leaves all outputs unchanged.
- R4: The index wraps modulo 32 in both directions.
- R5: Magnitude codes run from 0 to 8, where 8 is full current and 0 is no current. With k = index mod 16, phase 1 (cosine) has code 8 - min(k, 16-k) and is negative for index 9 to 23. Phase 2 (sine) has code 8 - |k-8| and is negative for index 17 to 31. A zero code always carries polarity 0.
- R6: `home_n` is low only while the index is at position 4.
- R7: A change on `ms_a`/`ms_b` with no step edge has no effect on any output. The step size is taken in the cycle in which the synchronised edge is applied.
- R8: While `drv_rst_n` is low or `uvlo` is high, the index is forced to position 4, `out_en` is 0 and step edges are dropped. `out_en` returns to 1 one clock after release.
- R9: Decay codes are 00 slow, 01 fast and 10 mixed. After a step, a phase whose magnitude code fell takes the mode on `decay_sel`, where 00 means slow, 01 fast, and 10 or 11 mixed. A phase whose code stayed the same or rose takes slow.
- R10: After the system reset, and while a driver reset or undervoltage is active, both decay requests are mixed.
- R11: A rising edge on `step_in` set up before clock edge E1 shows on the outputs after clock edge E3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| drv_rst_n | input | 1 | Driver reset, active low: forces home and turns the bridges off |
| uvlo | input | 1 | Undervoltage flag, active high: same effect as the driver reset |
| step_in | input | 1 | Step pulse, asynchronous; a rising edge advances the index |
| dir | input | 1 | Direction: 1 increasing angle, 0 decreasing |
| ms_a | input | 1 | Mode select, low bit |
| ms_b | input | 1 | Mode select, high bit |
| decay_sel | input | 2 | Decay mode used when a phase's current falls |
| ph1_mag | output | 4 | Phase 1 magnitude code (0 to 8) |
| ph1_neg | output | 1 | Phase 1 polarity, 1 = negative |
| ph2_mag | output | 4 | Phase 2 magnitude code (0 to 8) |
| ph2_neg | output | 1 | Phase 2 polarity, 1 = negative |
| home_n | output | 1 | Low while at the home position |
| out_en | output | 1 | Bridges commanded on |
| ph1_decay | output | 2 | Phase 1 decay request |
| ph2_decay | output | 2 | Phase 2 decay request |

## Verification
A synchronised step edge can reach the index register in the same cycle that a driver reset or undervoltage takes effect. The bench provokes this by moving the indexer away from home, raising `step_in`, and pulling `drv_rst_n` low at the falling clock edge just before the edge would be applied. The expected result is the home position with mixed decay and no extra step, and `step_in` is still high when the reset is released. The same collision is then repeated with `uvlo`. The second pair of events that can coincide is a mode change and a step. The bench changes the mode with no step and checks the outputs, then steps and checks that the new step size is used.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  typedef enum logic [1:0] {
    DK_SLOW  = 2'b00,
    DK_FAST  = 2'b01,
    DK_MIXED = 2'b10
  } decay_e;

  function automatic decay_e sel_to_decay(input logic [1:0] sel);
    case (sel)
      2'b00:   return DK_SLOW;
      2'b01:   return DK_FAST;
      default: return DK_MIXED;
    endcase
  endfunction
endpackage

// File: rtl/ustep_edge.sv
module ustep_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ustep_pos.sv
module ustep_pos #(
  parameter int IDX_W = 5,
  parameter int HOME  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             fire,
  input  logic             dir,
  input  logic             ms_a,
  input  logic             ms_b,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] nxt
);
  localparam int QTR = 1 << (IDX_W - 2);
  logic [IDX_W-1:0] inc;

  always_comb begin
    inc = IDX_W'(QTR >> {ms_b, ms_a});
    nxt = dir ? idx + inc : idx - inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= IDX_W'(HOME);
    else if (hold)  idx <= IDX_W'(HOME);
    else if (fire)  idx <= nxt;
  end

  // R3
  idx_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !hold) |=> $stable(idx));
  // R8
  hold_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (idx == IDX_W'(HOME)));
endmodule

// File: rtl/ustep_phase.sv
module ustep_phase #(
  parameter int IDX_W  = 5,
  parameter bit COSINE = 1'b1,
  parameter int MAG_W  = $clog2((1 << (IDX_W - 2)) + 1)
) (
  input  logic [IDX_W-1:0] idx,
  output logic [MAG_W-1:0] mag,
  output logic             neg
);
  localparam int Q = 1 << (IDX_W - 2);
  int h, p;

  always_comb begin
    h = int'(idx[IDX_W-2:0]);
    p = int'(idx);
  end

  generate
    if (COSINE) begin : g_cos
      always_comb begin
        mag = (h <= Q) ? MAG_W'(Q - h) : MAG_W'(h - Q);
        neg = (p > Q) && (p < 3 * Q);
      end
    end else begin : g_sin
      always_comb begin
        mag = (h <= Q) ? MAG_W'(h) : MAG_W'(2 * Q - h);
        neg = (p > 2 * Q);
      end
    end
  endgenerate
endmodule

// File: rtl/ustep_decay.sv
module ustep_decay
  import ustep_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             move,
  input  logic [MAG_W-1:0] old_mag,
  input  logic [MAG_W-1:0] new_mag,
  input  logic [1:0]       sel,
  output decay_e           decay
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     decay <= DK_MIXED;
    else if (hold)  decay <= DK_MIXED;
    else if (move)  decay <= (new_mag < old_mag) ? sel_to_decay(sel) : DK_SLOW;
  end

  // R9
  rise_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move && !hold && new_mag >= old_mag) |=> (decay == DK_SLOW));
  // R10
  hold_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (decay == DK_MIXED));
endmodule

// File: rtl/ustep_indexer.sv
module ustep_indexer
  import ustep_pkg::*;
#(
  parameter int IDX_W       = 5,
  parameter int SYNC_STAGES = 2,
  parameter int MAG_W       = $clog2((1 << (IDX_W - 2)) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_rst_n,
  input  logic             uvlo,
  input  logic             step_in,
  input  logic             dir,
  input  logic             ms_a,
  input  logic             ms_b,
  input  logic [1:0]       decay_sel,
  output logic [MAG_W-1:0] ph1_mag,
  output logic             ph1_neg,
  output logic [MAG_W-1:0] ph2_mag,
  output logic             ph2_neg,
  output logic             home_n,
  output logic             out_en,
  output logic [1:0]       ph1_decay,
  output logic [1:0]       ph2_decay
);
  localparam int Q    = 1 << (IDX_W - 2);
  localparam int HOME = Q / 2;

  logic             fire, hold, move;
  logic [IDX_W-1:0] idx, nxt;
  logic [MAG_W-1:0] cur_mag [2];
  logic [MAG_W-1:0] nxt_mag [2];
  logic             cur_neg [2];
  logic             nxt_neg [2];
  decay_e           dk      [2];

  assign hold = !drv_rst_n || uvlo;
  assign move = fire && !hold;

  ustep_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(step_in), .rise(fire)
  );

  ustep_pos #(.IDX_W(IDX_W), .HOME(HOME)) u_pos (
    .clk(clk), .rst_n(rst_n), .hold(hold), .fire(fire), .dir(dir),
    .ms_a(ms_a), .ms_b(ms_b), .idx(idx), .nxt(nxt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_ph
    ustep_phase #(.IDX_W(IDX_W), .COSINE(g == 0), .MAG_W(MAG_W)) u_cur (
      .idx(idx), .mag(cur_mag[g]), .neg(cur_neg[g])
    );
    ustep_phase #(.IDX_W(IDX_W), .COSINE(g == 0), .MAG_W(MAG_W)) u_nxt (
      .idx(nxt), .mag(nxt_mag[g]), .neg(nxt_neg[g])
    );
    ustep_decay #(.MAG_W(MAG_W)) u_dk (
      .clk(clk), .rst_n(rst_n), .hold(hold), .move(move),
      .old_mag(cur_mag[g]), .new_mag(nxt_mag[g]), .sel(decay_sel), .decay(dk[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_en <= 1'b0;
    else        out_en <= !hold;
  end

  assign ph1_mag   = cur_mag[0];
  assign ph1_neg   = cur_neg[0];
  assign ph2_mag   = cur_mag[1];
  assign ph2_neg   = cur_neg[1];
  assign home_n    = (idx != IDX_W'(HOME));
  assign ph1_decay = dk[0];
  assign ph2_decay = dk[1];

  // R5
  phase_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ph1_mag) + int'(ph2_mag)) == Q);
  // R6
  home_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !home_n |-> (ph1_mag == MAG_W'(HOME) && ph2_mag == MAG_W'(HOME) && !ph1_neg && !ph2_neg));
  // R8
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !out_en);
endmodule

// File: tb/sim_ustep_indexer.sv
`timescale 1ns/1ps
module sim_ustep_indexer;
  logic clk = 1'b0;
  logic rst_n = 1'b0, drv_rst_n = 1'b1, uvlo = 1'b0, step_in = 1'b0;
  logic dir = 1'b1, ms_a = 1'b0, ms_b = 1'b0;
  logic [1:0] decay_sel = 2'b10;
  logic [3:0] ph1_mag, ph2_mag;
  logic ph1_neg, ph2_neg, home_n, out_en;
  logic [1:0] ph1_decay, ph2_decay;

  always #2.5 clk = ~clk;

  ustep_indexer u0 (
    .clk(clk), .rst_n(rst_n), .drv_rst_n(drv_rst_n), .uvlo(uvlo), .step_in(step_in),
    .dir(dir), .ms_a(ms_a), .ms_b(ms_b), .decay_sel(decay_sel),
    .ph1_mag(ph1_mag), .ph1_neg(ph1_neg), .ph2_mag(ph2_mag), .ph2_neg(ph2_neg),
    .home_n(home_n), .out_en(out_en), .ph1_decay(ph1_decay), .ph2_decay(ph2_decay)
  );

  typedef struct {
    int l1; bit n1; int l2; bit n2; bit hn; bit en; int d1; int d2; string tag;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int n_vec = 0, n_bad = 0;
  int m_idx = 4, m_d1 = 2, m_d2 = 2;
  bit m_en = 0;
  bit done = 0;

  function automatic int lvl_cos(int i);
    int k = i % 16;
    int d = (k < 16 - k) ? k : 16 - k;
    return 8 - d;
  endfunction
  function automatic int lvl_sin(int i);
    int k = i % 16;
    int d = (k > 8) ? k - 8 : 8 - k;
    return 8 - d;
  endfunction
  function automatic int sel_map(logic [1:0] s);
    return (s == 2'b00) ? 0 : (s == 2'b01) ? 1 : 2;
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.l1 = lvl_cos(m_idx); e.n1 = (m_idx > 8 && m_idx < 24);
    e.l2 = lvl_sin(m_idx); e.n2 = (m_idx > 16);
    e.hn = (m_idx != 4); e.en = m_en; e.d1 = m_d1; e.d2 = m_d2; e.tag = tag;
    q.push_back(e);
    -> sample_ev;
  endtask

  task automatic model_step(bit d, bit a, bit b);
    int inc = 8 >> {b, a};
    int ni = d ? (m_idx + inc) % 32 : (m_idx - inc + 32) % 32;
    int s = sel_map(decay_sel);
    m_d1 = (lvl_cos(ni) < lvl_cos(m_idx)) ? s : 0;
    m_d2 = (lvl_sin(ni) < lvl_sin(m_idx)) ? s : 0;
    m_idx = ni;
  endtask

  task automatic do_step(bit d, bit a, bit b, string tag);
    @(negedge clk);
    dir = d; ms_a = a; ms_b = b; step_in = 1'b1;
    model_step(d, a, b);
    repeat (4) @(negedge clk);
    push(tag);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        e = q.pop_front();
        n_vec++;
        chk(e.tag, "ph1_mag", ph1_mag, e.l1);
        chk(e.tag, "ph1_neg", ph1_neg, e.n1);
        chk(e.tag, "ph2_mag", ph2_mag, e.l2);
        chk(e.tag, "ph2_neg", ph2_neg, e.n2);
        chk(e.tag, "home_n", home_n, e.hn);
        chk(e.tag, "out_en", out_en, e.en);
        chk(e.tag, "ph1_decay", ph1_decay, e.d1);
        chk(e.tag, "ph2_decay", ph2_decay, e.d2);
      end
    end
  end

  task automatic hold_collide(bit use_uvlo, string tag);
    @(negedge clk);
    step_in = 1'b1; dir = 1'b1; ms_a = 1'b1; ms_b = 1'b1;
    repeat (2) @(negedge clk);
    if (use_uvlo) uvlo = 1'b1; else drv_rst_n = 1'b0;
    m_idx = 4; m_d1 = 2; m_d2 = 2; m_en = 0;
    @(negedge clk);
    @(negedge clk);
    push(tag);
    if (use_uvlo) uvlo = 1'b0; else drv_rst_n = 1'b1;
    m_en = 1;
    repeat (3) @(negedge clk);
    push(tag);
    step_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin : driver
    repeat (3) @(negedge clk);
    push("R1 reset state, R10 mixed after reset");
    drv_rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    push("R8 driver reset held");
    drv_rst_n = 1'b1; m_en = 1;
    repeat (2) @(negedge clk);
    push("R8 out_en after release");

    decay_sel = 2'b10;
    for (int i = 0; i < 33; i++) do_step(1, 1, 1, "R2 R4 R5 R6 R9 R11 eighth step fwd");
    decay_sel = 2'b01;
    for (int i = 0; i < 6; i++) do_step(0, 0, 0, "R2 R4 full step rev");
    decay_sel = 2'b00;
    for (int i = 0; i < 9; i++) do_step(1, 1, 0, "R2 half step fwd");
    decay_sel = 2'b11;
    for (int i = 0; i < 17; i++) do_step(0, 0, 1, "R2 R4 R9 quarter step rev");
    for (int i = 0; i < 5; i++) do_step(0, 1, 1, "R9 eighth step rev");

    @(negedge clk); ms_a = 1'b0; ms_b = 1'b0;
    repeat (6) @(negedge clk);
    push("R7 mode change alone");
    do_step(1, 0, 0, "R7 new mode taken at edge");

    @(negedge clk); step_in = 1'b1; dir = 1'b1; ms_a = 1'b1; ms_b = 1'b1;
    model_step(1, 1, 1);
    repeat (8) @(negedge clk);
    push("R3 level held high");
    step_in = 1'b0;
    repeat (6) @(negedge clk);
    push("R3 falling edge ignored");

    do_step(1, 1, 0, "R3 step before uvlo");
    @(negedge clk); uvlo = 1'b1;
    m_idx = 4; m_d1 = 2; m_d2 = 2; m_en = 0;
    @(negedge clk); step_in = 1'b1;
    repeat (5) @(negedge clk); step_in = 1'b0;
    repeat (4) @(negedge clk);
    push("R8 uvlo forces home and drops steps");
    uvlo = 1'b0; m_en = 1;
    repeat (2) @(negedge clk);
    push("R8 uvlo release");

    do_step(1, 0, 0, "R8 move off home");
    hold_collide(0, "R8 step edge with driver reset");
    do_step(0, 1, 0, "R8 move off home again");
    hold_collide(1, "R8 step edge with uvlo");
    do_step(1, 0, 1, "R6 leave home after collisions");

    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin : finisher
    fork
      wait (done);
      begin
        #500000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule